// File: doc/BRIEF.md
# Clock Generator Configuration Register Slave

This block is the serial control port of a multi-output clock generator. A host on a two-wire bus (SMBus-style: open-drain data, host-driven clock) reads and writes a bank of three configuration registers. Four transaction types are supported: single indexed write, single indexed read, sequential block write and sequential block read. The first byte after the address is a command code. Its top bit chooses between indexed and block access, and its low bits carry the register index.

The register contents are decoded into control fields for the rest of the generator:
- a run/park flag for each of the five clock outputs;
- power-down controls for the two PLLs that can be shut off;
- the frequency choice for the selectable audio clock;
- the depth of the spread applied to the processor clock.

An external output-enable pin overrides the register bits and places every output in high impedance.

Both bus lines are sampled with the system clock through two-flop synchronizers. Start, stop and clock edges are then found from the synchronized values. The data line is only ever pulled low, never driven high.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: After reset, register 1 holds 0xF7 and register 2 holds 0x02. With the enable pin low, `clk_run` is 5'b01111, `clk_hiz` is 0, `spread_pll_on` is 1, `fix_pll_on` is 0, `audio_sel` is 1 and `spread_depth` is 2.
- R2: The slave acknowledges only the 7-bit address 7'h69, sent as 0xD2 for a write or 0xD3 for a read. Any other address gets no acknowledge, and the rest of that transaction is ignored.
- R3: A command byte with bit 7 set selects indexed access, and bits 6:0 give the register index. An indexed write stores the single data byte that follows the command. An indexed read (command, repeated start, read address) returns that register. All bytes travel MSB first.
- R4: Register 0 reads 0x1F and is read-only. A write to it is acknowledged and has no effect.
- R5: A write to an index of 3 or more is acknowledged and discarded. A read from such an index returns 0x00.
- R6: A command byte with bit 7 clear selects block access. In a block write, the first byte after the command is a byte count. Data bytes then go to registers 0, 1 and 2 in that order. Data bytes past the count, or past register 2, are acknowledged and ignored.
- R7: A block read returns the count 0x03 first, then registers 0, 1 and 2. It stops when the host withholds its acknowledge.
- R8: `clk_run[i]` equals register 1 bit (7-i) when the enable pin is low. The index order is [0] reference, [1] spread clock, [2] 48 MHz, [3] selectable audio, [4] fixed audio. `spread_pll_on` is register 1 bit 6, `fix_pll_on` is bit 3, and `audio_sel` is bit 0 (1 selects 24.576 MHz).
- R9: Register 2 bits 2:0 set `spread_depth`: 001→1 (-0.5%), 010→2 (-1%), 100→3 (-2%), 110→4 (-3%). Every other code gives 0 (no spread).
- R10: While `oe_pin` is 1, all `clk_hiz` bits are 1 and all `clk_run` bits are 0. A run bit and a high-impedance bit are never set together.
- R11: A start or stop that arrives in the middle of a byte drops that byte. Registers written earlier keep their values, and the slave releases the data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the wire (asynchronous) |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| oe_pin | input | 1 | External enable; 1 forces all outputs to high impedance |
| clk_run | output | 5 | Per-output run flag; 0 parks that output low |
| clk_hiz | output | 5 | Per-output high-impedance control |
| spread_pll_on | output | 1 | Power for the spread-clock PLL |
| fix_pll_on | output | 1 | Power for the fixed-audio PLL |
| audio_sel | output | 1 | Selectable audio frequency choice |
| spread_depth | output | 3 | Decoded spread depth code |

## Verification
Some checks hold on every cycle and are covered by assertions:
- the enable-pin override of every output;
- the exclusion between the run and high-impedance flags;
- the decode of odd spread codes to no spread;
- registers changing only when a byte completes;
- release of the data line after a stop or after a foreign address.

Other behaviour only shows across whole transactions, so the bench scenarios cover it:
- address filtering;
- routing of the index and the byte count;
- the read-only first register;
- discarded high indexes;
- the sequence returned by a block read;
- the survival of register contents across transfers cut off mid-byte.

// File: rtl/clkcfg_pkg.sv
`timescale 1ns/1ps
package clkcfg_pkg;
    localparam int         REG_COUNT = 3;
    localparam int         NUM_OUT   = 5;
    localparam logic [6:0] DEV_ADDR  = 7'h69;

    typedef enum logic [2:0] {S_IDLE, S_RX, S_RX_ACK, S_TX, S_TX_ACK} bus_state_t;
    typedef enum logic [1:0] {K_ADDR, K_CMD, K_DATA} rx_kind_t;
    typedef enum logic [2:0] {
        SPR_NONE = 3'd0, SPR_HALF = 3'd1, SPR_ONE = 3'd2, SPR_TWO = 3'd3, SPR_THREE = 3'd4
    } spread_depth_t;

    function automatic logic [7:0] reg_default(int idx);
        case (idx)
            0:       return 8'h1F;
            1:       return 8'hF7;
            2:       return 8'h02;
            default: return 8'h00;
        endcase
    endfunction

    function automatic spread_depth_t decode_spread(logic [2:0] code);
        case (code)
            3'b001:  return SPR_HALF;
            3'b010:  return SPR_ONE;
            3'b100:  return SPR_TWO;
            3'b110:  return SPR_THREE;
            default: return SPR_NONE;
        endcase
    endfunction
endpackage

// File: rtl/clkcfg_sync.sv
`timescale 1ns/1ps
module clkcfg_sync #(
    parameter int   STAGES   = 2,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/clkcfg_bus_slave.sv
`timescale 1ns/1ps
module clkcfg_bus_slave
    import clkcfg_pkg::*;
#(
    parameter int         REGS = REG_COUNT,
    parameter logic [6:0] ADDR = DEV_ADDR
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_s,
    input  logic                 sda_s,
    output logic                 sda_pull,
    output logic [REGS-1:0][7:0] regs
);
    localparam logic [7:0] COUNT_BYTE = 8'(REGS);

    bus_state_t state;
    rx_kind_t   kind;
    logic [7:0] sh, byte_cnt, wr_idx, tx_idx, next_tx, wr_addr;
    logic [3:0] bit_cnt;
    logic [6:0] offset;
    logic       rw, blk, host_ack, scl_d, sda_d, wr_en;
    logic       start_evt, stop_evt, scl_rise, scl_fall, byte_done;
    logic [7:0] mem [REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign byte_done = (state == S_RX) && scl_fall && (bit_cnt == 4'd8);

    function automatic logic [7:0] fetch(logic [7:0] idx, logic [REGS-1:0][7:0] r);
        logic [7:0] v;
        v = 8'h00;
        for (int i = 0; i < REGS; i++)
            if (idx == 8'(i)) v = r[i];
        return v;
    endfunction

    always_comb begin
        regs[0] = reg_default(0);
        for (int i = 1; i < REGS; i++) regs[i] = mem[i];
    end

    always_comb begin
        if (blk) next_tx = (tx_idx == 8'd0) ? COUNT_BYTE : fetch(tx_idx - 8'd1, regs);
        else     next_tx = fetch({1'b0, offset}, regs);
    end

    always_comb begin
        wr_en   = 1'b0;
        wr_addr = {1'b0, offset};
        if (byte_done && kind == K_DATA) begin
            if (blk) begin
                wr_addr = wr_idx - 8'd1;
                wr_en   = (wr_idx != 8'd0) && (wr_addr < byte_cnt);
            end else begin
                wr_en   = (wr_idx == 8'd0);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REGS; i++) mem[i] <= reg_default(i);
        end else begin
            for (int i = 1; i < REGS; i++)
                if (wr_en && wr_addr == 8'(i)) mem[i] <= sh;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;  kind <= K_ADDR;  sh <= '0;  bit_cnt <= '0;
            rw <= 1'b0;  blk <= 1'b0;  offset <= '0;  byte_cnt <= '0;
            wr_idx <= '0;  tx_idx <= '0;  host_ack <= 1'b0;
        end else if (start_evt) begin
            state <= S_RX;  kind <= K_ADDR;  bit_cnt <= '0;
            wr_idx <= '0;  tx_idx <= '0;
        end else if (stop_evt) begin
            state <= S_IDLE;
        end else begin
            unique case (state)
                S_RX: begin
                    if (scl_rise && bit_cnt < 4'd8) begin
                        sh      <= {sh[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_done) begin
                        state <= S_RX_ACK;
                        unique case (kind)
                            K_ADDR: begin
                                if (sh[7:1] != ADDR) state <= S_IDLE;
                                else                 rw    <= sh[0];
                            end
                            K_CMD: begin
                                blk    <= ~sh[7];
                                offset <= sh[6:0];
                            end
                            default: begin
                                if (blk && wr_idx == 8'd0) byte_cnt <= sh;
                                if (wr_idx != 8'hFF)       wr_idx   <= wr_idx + 8'd1;
                            end
                        endcase
                    end
                end
                S_RX_ACK: if (scl_fall) begin
                    bit_cnt <= '0;
                    if (kind == K_ADDR && rw) begin
                        state <= S_TX;
                        sh    <= next_tx;
                        if (tx_idx != 8'hFF) tx_idx <= tx_idx + 8'd1;
                    end else begin
                        state <= S_RX;
                        kind  <= (kind == K_ADDR) ? K_CMD : K_DATA;
                    end
                end
                S_TX: begin
                    if (scl_rise) bit_cnt <= bit_cnt + 4'd1;
                    else if (scl_fall) begin
                        if (bit_cnt == 4'd8) state <= S_TX_ACK;
                        else                 sh    <= {sh[6:0], 1'b0};
                    end
                end
                S_TX_ACK: begin
                    if (scl_rise) host_ack <= ~sda_s;
                    else if (scl_fall) begin
                        if (host_ack) begin
                            state   <= S_TX;
                            sh      <= next_tx;
                            bit_cnt <= '0;
                            if (tx_idx != 8'hFF) tx_idx <= tx_idx + 8'd1;
                        end else begin
                            state <= S_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_pull = (state == S_RX_ACK) || (state == S_TX && !sh[7]);

    p_hold_regs_r6: assert property (@(posedge clk) disable iff (rst)
        !byte_done |=> $stable(regs));
    p_stop_release_r11: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> (state == S_IDLE && !sda_pull));
    p_nack_foreign_r2: assert property (@(posedge clk) disable iff (rst)
        (byte_done && kind == K_ADDR && sh[7:1] != ADDR) |=> (state == S_IDLE && !sda_pull));
endmodule

// File: rtl/clkcfg_out_ctrl.sv
`timescale 1ns/1ps
module clkcfg_out_ctrl
    import clkcfg_pkg::*;
#(
    parameter int OUTS = NUM_OUT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [7:0]      ctrl_reg,
    input  logic [2:0]      spread_code,
    input  logic            oe_pin,
    output logic [OUTS-1:0] clk_run,
    output logic [OUTS-1:0] clk_hiz,
    output logic            spread_pll_on,
    output logic            fix_pll_on,
    output logic            audio_sel,
    output spread_depth_t   spread_depth
);
    for (genvar i = 0; i < OUTS; i++) begin : g_out
        assign clk_run[i] = ctrl_reg[7-i] & ~oe_pin;
        assign clk_hiz[i] = oe_pin;
    end

    assign spread_pll_on = ctrl_reg[6];
    assign fix_pll_on    = ctrl_reg[3];
    assign audio_sel     = ctrl_reg[0];
    assign spread_depth  = decode_spread(spread_code);

    p_oe_hiz_r10: assert property (@(posedge clk) disable iff (rst)
        oe_pin |-> (&clk_hiz && clk_run == '0));
    p_run_hiz_excl_r8: assert property (@(posedge clk) disable iff (rst)
        (clk_run & clk_hiz) == '0);
    p_nospread_odd_r9: assert property (@(posedge clk) disable iff (rst)
        (spread_code[0] && spread_code[2:1] != 2'b00) |-> spread_depth == SPR_NONE);
endmodule

// File: rtl/clkgen_cfg_slave.sv
`timescale 1ns/1ps
module clkgen_cfg_slave
    import clkcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic       oe_pin,
    output logic [4:0] clk_run,
    output logic [4:0] clk_hiz,
    output logic       spread_pll_on,
    output logic       fix_pll_on,
    output logic       audio_sel,
    output logic [2:0] spread_depth
);
    logic                      scl_s, sda_s;
    logic [REG_COUNT-1:0][7:0] regs;
    spread_depth_t             depth;
    logic                      unused_bits;

    clkcfg_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync_scl (
        .clk(clk), .rst(rst), .din(scl_i), .dout(scl_s));
    clkcfg_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync_sda (
        .clk(clk), .rst(rst), .din(sda_i), .dout(sda_s));

    clkcfg_bus_slave #(.REGS(REG_COUNT), .ADDR(DEV_ADDR)) u_bus (
        .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
        .sda_pull(sda_pull_o), .regs(regs));

    clkcfg_out_ctrl #(.OUTS(NUM_OUT)) u_out (
        .clk(clk), .rst(rst), .ctrl_reg(regs[1]), .spread_code(regs[2][2:0]),
        .oe_pin(oe_pin), .clk_run(clk_run), .clk_hiz(clk_hiz),
        .spread_pll_on(spread_pll_on), .fix_pll_on(fix_pll_on),
        .audio_sel(audio_sel), .spread_depth(depth));

    assign spread_depth = depth;
    assign unused_bits  = ^{regs[0], regs[2][7:3]};
endmodule

// File: tb/clkgen_cfg_slave_bench.sv
`timescale 1ns/1ps
module clkgen_cfg_slave_bench;
    localparam int Q = 10;

    logic clk = 1'b0, rst = 1'b1, scl = 1'b1, host_sda = 1'b1, oe_pin = 1'b0;
    logic sda_pull, spread_pll_on, fix_pll_on, audio_sel;
    logic [4:0] clk_run, clk_hiz;
    logic [2:0] spread_depth;
    logic sda_line;
    int checks = 0, errors = 0;
    bit done = 0;

    assign sda_line = host_sda & ~sda_pull;

    always #2.5 clk = ~clk;

    clkgen_cfg_slave u_clkgen_cfg_slave (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_pull_o(sda_pull),
        .oe_pin(oe_pin), .clk_run(clk_run), .clk_hiz(clk_hiz),
        .spread_pll_on(spread_pll_on), .fix_pll_on(fix_pll_on),
        .audio_sel(audio_sel), .spread_depth(spread_depth));

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_q(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        host_sda = 1'b1; wait_q(); scl = 1'b1; wait_q();
        host_sda = 1'b0; wait_q(); scl = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; wait_q(); scl = 1'b1; wait_q();
        host_sda = 1'b1; wait_q(); wait_q();
    endtask

    task automatic send_bit(logic b);
        host_sda = b; wait_q(); scl = 1'b1; wait_q(); wait_q(); scl = 1'b0; wait_q();
    endtask

    task automatic recv_bit(output logic v);
        host_sda = 1'b1; wait_q(); scl = 1'b1; wait_q(); v = sda_line;
        wait_q(); scl = 1'b0; wait_q();
    endtask

    task automatic write_byte(logic [7:0] b, output logic ack);
        logic v;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(v);
        ack = ~v;
    endtask

    task automatic read_byte(logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) recv_bit(b[i]);
        send_bit(~give_ack);
    endtask

    task automatic reg_write(logic [7:0] cmd, logic [7:0] data, output logic all_ack);
        logic a0, a1, a2;
        bus_start(); write_byte(8'hD2, a0); write_byte(cmd, a1); write_byte(data, a2); bus_stop();
        all_ack = a0 & a1 & a2;
    endtask

    task automatic reg_read(logic [7:0] cmd, output logic [7:0] data);
        logic a0, a1, a2;
        bus_start(); write_byte(8'hD2, a0); write_byte(cmd, a1);
        bus_start(); write_byte(8'hD3, a2); read_byte(1'b0, data); bus_stop();
    endtask

    task automatic t_reset();
        chk("R1 clk_run", clk_run, 5'b01111);
        chk("R1 clk_hiz", clk_hiz, 5'b00000);
        chk("R1 spread_pll_on", spread_pll_on, 1);
        chk("R1 fix_pll_on", fix_pll_on, 0);
        chk("R1 audio_sel", audio_sel, 1);
        chk("R1 spread_depth", spread_depth, 2);
        chk("R1 sda released", sda_pull, 0);
    endtask

    task automatic t_oe();
        oe_pin = 1'b1; repeat (3) @(negedge clk);
        chk("R10 hiz all", clk_hiz, 5'b11111);
        chk("R10 run none", clk_run, 5'b00000);
        oe_pin = 1'b0; repeat (3) @(negedge clk);
        chk("R10 run restored", clk_run, 5'b01111);
        chk("R10 hiz cleared", clk_hiz, 5'b00000);
    endtask

    task automatic t_addr();
        logic a; logic [7:0] d;
        bus_start(); write_byte(8'hA0, a); write_byte(8'h81, a); write_byte(8'h00, a); bus_stop();
        chk("R2 foreign address nack", a, 0);
        reg_read(8'h81, d);
        chk("R2 register untouched", d, 8'hF7);
    endtask

    task automatic t_byte_rw();
        logic a; logic [7:0] d;
        reg_write(8'h81, 8'h08, a);
        chk("R3 byte write acked", a, 1);
        reg_read(8'h81, d);
        chk("R3 byte read back", d, 8'h08);
        chk("R8 run map", clk_run, 5'b10000);
        chk("R8 spread pll off", spread_pll_on, 0);
        chk("R8 fixed pll on", fix_pll_on, 1);
        chk("R8 audio select", audio_sel, 0);
    endtask

    task automatic t_reg0();
        logic a; logic [7:0] d;
        reg_write(8'h80, 8'h55, a);
        chk("R4 write acked", a, 1);
        reg_read(8'h80, d);
        chk("R4 reg0 fixed", d, 8'h1F);
    endtask

    task automatic t_high();
        logic a; logic [7:0] d;
        reg_write(8'h85, 8'h77, a);
        chk("R5 high index acked", a, 1);
        reg_read(8'h85, d);
        chk("R5 high index reads zero", d, 8'h00);
        reg_read(8'h82, d);
        chk("R5 reg2 untouched", d, 8'h02);
    endtask

    task automatic t_spread();
        logic a;
        logic [2:0] codes [8] = '{3'd1, 3'd4, 3'd6, 3'd3, 3'd7, 3'd0, 3'd5, 3'd2};
        logic [2:0] exps  [8] = '{3'd1, 3'd3, 3'd4, 3'd0, 3'd0, 3'd0, 3'd0, 3'd2};
        for (int i = 0; i < 8; i++) begin
            reg_write(8'h82, {5'b0, codes[i]}, a);
            chk("R9 spread depth", spread_depth, exps[i]);
        end
    endtask

    task automatic t_block_write();
        logic a0, a1, a2, a3, a4, a5, a6; logic [7:0] d;
        bus_start(); write_byte(8'hD2, a0); write_byte(8'h00, a1); write_byte(8'h03, a2);
        write_byte(8'h00, a3); write_byte(8'h35, a4); write_byte(8'h04, a5); write_byte(8'h99, a6); bus_stop();
        chk("R6 all bytes acked", {a0, a1, a2, a3, a4, a5, a6}, 7'h7F);
        chk("R6 run after block", clk_run, 5'b01100);
        chk("R6 depth after block", spread_depth, 3);
        bus_start(); write_byte(8'hD2, a0); write_byte(8'h00, a1); write_byte(8'h02, a2);
        write_byte(8'h00, a3); write_byte(8'hAA, a4); write_byte(8'h06, a5); bus_stop();
        reg_read(8'h81, d);
        chk("R6 reg1 within count", d, 8'hAA);
        reg_read(8'h82, d);
        chk("R6 reg2 beyond count kept", d, 8'h04);
    endtask

    task automatic t_block_read();
        logic a0, a1, a2; logic [7:0] c, r0, r1, r2;
        bus_start(); write_byte(8'hD2, a0); write_byte(8'h00, a1);
        bus_start(); write_byte(8'hD3, a2);
        read_byte(1'b1, c); read_byte(1'b1, r0); read_byte(1'b1, r1); read_byte(1'b0, r2); bus_stop();
        chk("R7 count", c, 8'h03);
        chk("R7 reg0", r0, 8'h1F);
        chk("R7 reg1", r1, 8'hAA);
        chk("R7 reg2", r2, 8'h04);
    endtask

    task automatic t_abort();
        logic a; logic [7:0] d;
        bus_start(); write_byte(8'hD2, a); write_byte(8'h81, a);
        for (int i = 7; i >= 4; i--) send_bit(d[0] ^ 1'b1);
        bus_stop();
        repeat (4) @(negedge clk);
        chk("R11 line released after stop", sda_pull, 0);
        bus_start(); write_byte(8'hD2, a); write_byte(8'h81, a);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_start(); write_byte(8'hD3, a); read_byte(1'b0, d); bus_stop();
        chk("R11 reg1 kept after aborts", d, 8'hAA);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_oe();
        t_addr();
        t_byte_rw();
        t_reg0();
        t_high();
        t_spread();
        t_block_write();
        t_block_read();
        t_abort();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule